// File: doc/BRIEF.md
# Flash programming command sequencer

The sequencer sits between a host word stream and a flash array. The host pushes 32-bit words through a valid/ready input. Each command opens with a header word that packs a transfer length and an operation code, and an address word follows it. A read command then fetches consecutive words from the array and returns them on a valid/ready output stream. A write command takes the following data words, stores them in a buffer the size of one page, and hands that buffer to the array whenever the transfer reaches the end of a page or runs out of words.

Two variants change what happens around each page program. The erase variants erase the page first. The lock variants raise a lock-set strobe once, after the last page program has completed. The array talks back through a busy flag. It reads the staged page through an index/data port while it programs. The address advances by one word (4 bytes) per transfer and carries straight across page boundaries.

Top module: `flash_cmd_seq`

## Requirements
- R1: The header word carries the word count N in bits [31:16] and the operation code in bits [7:0]. Bits [15:8] are ignored. The codes are read 0x1E, write 0x01, write+lock 0x02, erase+write 0x03 and erase+write+lock 0x04. The next input word is the byte start address.
- R2: A read returns N words on the output stream, in the order address, address+4, up to address+4(N-1), each taken from the array's read port. Each word stays on out_data_o, with out_valid_o held high, until out_ready_i accepts it.
- R3: An unknown code, or a start address whose bits [1:0] are not zero, raises err_o for one cycle after the address word. That command makes no array strobe, and the next input word is parsed as a header.
- R4: A count of zero ends the command after the address word, with no array strobe and no error.
- R5: A page program (fl_prog_o) gives the byte address of the page base (low log2(PAGE_WORDS)+2 bits zero). While busy, the array reads through fl_buf_idx_i/fl_buf_data_o each word loaded at its in-page index. Every word that was not loaded reads 0xFFFFFFFF.
- R6: The buffer is flushed after a data word at in-page index PAGE_WORDS-1 and after the command's last data word. Each page a write touches is programmed exactly once, and the address keeps advancing across page boundaries.
- R7: For erase variants, each page program follows an erase strobe (fl_erase_o) at the same page base address. Plain writes issue no erase.
- R8: Lock variants issue one fl_lock_o, at the base address of the last page written, after that page's program has finished. Other commands issue none.
- R9: The array raises fl_busy_i in the cycle after an erase, program or lock strobe and holds it until the operation ends. While fl_busy_i is high, in_ready_o is low and no strobe is issued.
- R10: After reset, in_ready_o is high, while out_valid_o, err_o and all array strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Host word valid |
| in_ready_o | output | 1 | Host word accepted when high with valid |
| in_data_i | input | 32 | Host word: header, address or write data |
| out_valid_o | output | 1 | Read word valid |
| out_ready_i | input | 1 | Consumer accepts read word |
| out_data_o | output | 32 | Read word |
| err_o | output | 1 | One-cycle pulse on a rejected command |
| fl_addr_o | output | ADDR_W | Byte address for read, or page base for erase/program/lock |
| fl_rd_o | output | 1 | Read strobe; data expected on fl_rdata_i next cycle |
| fl_rdata_i | input | 32 | Array read data |
| fl_erase_o | output | 1 | Page erase strobe |
| fl_prog_o | output | 1 | Page program strobe |
| fl_lock_o | output | 1 | Lock-set strobe |
| fl_busy_i | input | 1 | Array operation in progress |
| fl_buf_idx_i | input | log2(PAGE_WORDS) | Buffer word index the array reads |
| fl_buf_data_o | output | 32 | Buffer word at fl_buf_idx_i |

## Verification
The bench drives a list of commands through a behavioural array whose cells start at non-erased values and are programmed by AND. Reading the data back after each write therefore shows three things: whether an erase happened, whether unloaded buffer words stayed at all ones, and whether words landed at the right indices. A short write that straddles a page boundary, a 130-word erase+write+lock that spans two pages, and a single word at a page's last index separate a flush on page end from a flush on count end. Bad codes, a misaligned address and a zero count are placed between good commands, so the bench sees whether the header that follows each one is still parsed correctly. A stalled read consumer and the busy/ready monitor cover the two handshakes.

// File: rtl/fseq_pkg.sv
`timescale 1ns/1ps
package fseq_pkg;
  localparam logic [7:0] OPC_READ = 8'h1E;
  localparam logic [7:0] OPC_WP   = 8'h01;
  localparam logic [7:0] OPC_WPL  = 8'h02;
  localparam logic [7:0] OPC_EWP  = 8'h03;
  localparam logic [7:0] OPC_EWPL = 8'h04;

  typedef struct packed {
    logic ok;
    logic rd;
    logic erase;
    logic lock;
  } cmd_t;

  typedef enum logic [3:0] {
    S_HDR, S_ADR, S_RD_REQ, S_RD_CAP, S_RD_OUT, S_WR,
    S_ERASE, S_ERASE_W, S_PROG, S_PROG_W, S_LOCK, S_LOCK_W
  } state_e;
endpackage

// File: rtl/fseq_hdr_decode.sv
`timescale 1ns/1ps
module fseq_hdr_decode
  import fseq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_field_i,
  input  logic [7:0]       opc_i,
  output logic [CNT_W-1:0] cnt_o,
  output cmd_t             cmd_o
);
  assign cnt_o = cnt_field_i;

  always_comb begin
    cmd_o = '0;
    unique case (opc_i)
      OPC_READ: cmd_o = '{ok: 1'b1, rd: 1'b1, erase: 1'b0, lock: 1'b0};
      OPC_WP:   cmd_o = '{ok: 1'b1, rd: 1'b0, erase: 1'b0, lock: 1'b0};
      OPC_WPL:  cmd_o = '{ok: 1'b1, rd: 1'b0, erase: 1'b0, lock: 1'b1};
      OPC_EWP:  cmd_o = '{ok: 1'b1, rd: 1'b0, erase: 1'b1, lock: 1'b0};
      OPC_EWPL: cmd_o = '{ok: 1'b1, rd: 1'b0, erase: 1'b1, lock: 1'b1};
      default:  cmd_o = '0;
    endcase
  end
endmodule

// File: rtl/fseq_addr_cnt.sv
`timescale 1ns/1ps
module fseq_addr_cnt #(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int PAGE_WORDS = 128
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          load_cnt_i,
  input  logic [CNT_W-1:0]              cnt_i,
  input  logic                          load_addr_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic                          step_i,
  output logic [ADDR_W-1:0]             addr_o,
  output logic                          cnt_zero_o,
  output logic                          last_o,
  output logic                          page_end_o,
  output logic [$clog2(PAGE_WORDS)-1:0] widx_o
);
  localparam int IDX_W = $clog2(PAGE_WORDS);
  localparam int PB_W  = IDX_W + 2;

  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (load_addr_i)      addr_q <= addr_i;
      else if (step_i)      addr_q <= addr_q + ADDR_W'(4);
      if (load_cnt_i)       cnt_q  <= cnt_i;
      else if (step_i)      cnt_q  <= cnt_q - CNT_W'(1);
    end
  end

  assign addr_o     = addr_q;
  assign widx_o     = addr_q[PB_W-1:2];
  assign cnt_zero_o = (cnt_q == '0);
  assign last_o     = (cnt_q == CNT_W'(1));
  assign page_end_o = (widx_o == IDX_W'(PAGE_WORDS - 1));

  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_addr_i |=> addr_o == $past(addr_o) + ADDR_W'(4)); // R2
  AST_NO_STEP_PAST_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> !cnt_zero_o); // R6
endmodule

// File: rtl/fseq_load_buf.sv
`timescale 1ns/1ps
module fseq_load_buf #(
  parameter int DATA_W     = 32,
  parameter int PAGE_WORDS = 128
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [$clog2(PAGE_WORDS)-1:0] widx_i,
  input  logic [DATA_W-1:0]             wdata_i,
  input  logic                          clr_i,
  input  logic [$clog2(PAGE_WORDS)-1:0] ridx_i,
  output logic [DATA_W-1:0]             rdata_o
);
  logic [DATA_W-1:0]     mem_q [PAGE_WORDS];
  logic [PAGE_WORDS-1:0] vld_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[widx_i] <= wdata_i;
  end

  // valid mask stands in for an all-ones refill of the page
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     vld_q <= '0;
    else if (clr_i)  vld_q <= '0;
    else if (we_i)   vld_q[widx_i] <= 1'b1;
  end

  assign rdata_o = vld_q[ridx_i] ? mem_q[ridx_i] : '1;

  AST_CLR_ERASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> rdata_o == '1); // R5
  AST_NO_WR_ON_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clr_i && we_i)); // R5
endmodule

// File: rtl/flash_cmd_seq.sv
`timescale 1ns/1ps
module flash_cmd_seq
  import fseq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int PAGE_WORDS = 128
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          in_valid_i,
  output logic                          in_ready_o,
  input  logic [31:0]                   in_data_i,
  output logic                          out_valid_o,
  input  logic                          out_ready_i,
  output logic [31:0]                   out_data_o,
  output logic                          err_o,
  output logic [ADDR_W-1:0]             fl_addr_o,
  output logic                          fl_rd_o,
  input  logic [31:0]                   fl_rdata_i,
  output logic                          fl_erase_o,
  output logic                          fl_prog_o,
  output logic                          fl_lock_o,
  input  logic                          fl_busy_i,
  input  logic [$clog2(PAGE_WORDS)-1:0] fl_buf_idx_i,
  output logic [31:0]                   fl_buf_data_o
);
  localparam int IDX_W = $clog2(PAGE_WORDS);
  localparam int PB_W  = IDX_W + 2;

  state_e            st_q, st_d;
  cmd_t              hdr_cmd, cmd_q;
  logic [CNT_W-1:0]  hdr_cnt;
  logic [ADDR_W-1:0] cur_addr, page_q;
  logic [IDX_W-1:0]  widx;
  logic              cnt_zero, cnt_last, page_end;
  logic              final_q, err_q, out_v_q;
  logic [31:0]       out_q;
  logic              acc, addr_good, ld_cnt, ld_addr, step, buf_we, buf_clr;

  fseq_hdr_decode #(.CNT_W(CNT_W)) u_dec (
    .cnt_field_i (in_data_i[16 +: CNT_W]),
    .opc_i       (in_data_i[7:0]),
    .cnt_o       (hdr_cnt),
    .cmd_o       (hdr_cmd)
  );

  fseq_addr_cnt #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_WORDS(PAGE_WORDS)) u_ac (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_cnt_i  (ld_cnt),
    .cnt_i       (hdr_cnt),
    .load_addr_i (ld_addr),
    .addr_i      (in_data_i[ADDR_W-1:0]),
    .step_i      (step),
    .addr_o      (cur_addr),
    .cnt_zero_o  (cnt_zero),
    .last_o      (cnt_last),
    .page_end_o  (page_end),
    .widx_o      (widx)
  );

  fseq_load_buf #(.DATA_W(32), .PAGE_WORDS(PAGE_WORDS)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (buf_we),
    .widx_i  (widx),
    .wdata_i (in_data_i),
    .clr_i   (buf_clr),
    .ridx_i  (fl_buf_idx_i),
    .rdata_o (fl_buf_data_o)
  );

  assign in_ready_o = !fl_busy_i && (st_q == S_HDR || st_q == S_ADR || st_q == S_WR);
  assign acc        = in_valid_i && in_ready_o;
  assign addr_good  = cmd_q.ok && (in_data_i[1:0] == 2'b00);
  assign ld_cnt     = (st_q == S_HDR) && acc;
  assign ld_addr    = (st_q == S_ADR) && acc && addr_good && !cnt_zero;
  assign buf_we     = (st_q == S_WR) && acc;
  assign step       = buf_we || ((st_q == S_RD_OUT) && out_ready_i);
  assign buf_clr    = (st_q == S_PROG_W) && !fl_busy_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_HDR:     if (acc) st_d = S_ADR;
      S_ADR:     if (acc) begin
                   if (!addr_good || cnt_zero) st_d = S_HDR;
                   else if (cmd_q.rd)          st_d = S_RD_REQ;
                   else                        st_d = S_WR;
                 end
      S_RD_REQ:  st_d = S_RD_CAP;
      S_RD_CAP:  st_d = S_RD_OUT;
      S_RD_OUT:  if (out_ready_i) st_d = cnt_last ? S_HDR : S_RD_REQ;
      S_WR:      if (acc && (cnt_last || page_end)) st_d = cmd_q.erase ? S_ERASE : S_PROG;
      S_ERASE:   st_d = S_ERASE_W;
      S_ERASE_W: if (!fl_busy_i) st_d = S_PROG;
      S_PROG:    st_d = S_PROG_W;
      S_PROG_W:  if (!fl_busy_i) begin
                   if (!final_q)        st_d = S_WR;
                   else if (cmd_q.lock) st_d = S_LOCK;
                   else                 st_d = S_HDR;
                 end
      S_LOCK:    st_d = S_LOCK_W;
      S_LOCK_W:  if (!fl_busy_i) st_d = S_HDR;
      default:   st_d = S_HDR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_HDR;
      cmd_q   <= '0;
      final_q <= 1'b0;
      page_q  <= '0;
      err_q   <= 1'b0;
      out_v_q <= 1'b0;
      out_q   <= '0;
    end else begin
      st_q  <= st_d;
      err_q <= (st_q == S_ADR) && acc && !addr_good;
      if (ld_cnt) cmd_q <= hdr_cmd;
      if (buf_we) begin
        final_q <= cnt_last;
        page_q  <= {cur_addr[ADDR_W-1:PB_W], PB_W'(0)};
      end
      if (st_q == S_RD_CAP) begin
        out_q   <= fl_rdata_i;
        out_v_q <= 1'b1;
      end else if (st_q == S_RD_OUT && out_ready_i) begin
        out_v_q <= 1'b0;
      end
    end
  end

  assign out_valid_o = out_v_q;
  assign out_data_o  = out_q;
  assign err_o       = err_q;
  assign fl_rd_o     = (st_q == S_RD_REQ);
  assign fl_erase_o  = (st_q == S_ERASE);
  assign fl_prog_o   = (st_q == S_PROG);
  assign fl_lock_o   = (st_q == S_LOCK);
  assign fl_addr_o   = (st_q == S_RD_REQ) ? cur_addr : page_q;

  AST_NO_STROBE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_busy_i |-> !(fl_rd_o || fl_erase_o || fl_prog_o || fl_lock_o)); // R9
  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fl_rd_o, fl_erase_o, fl_prog_o, fl_lock_o})); // R9
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o)); // R2
  AST_PROG_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_prog_o |-> fl_addr_o[PB_W-1:0] == '0); // R5
  AST_ERR_NO_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !(fl_rd_o || fl_erase_o || fl_prog_o || fl_lock_o) && !out_valid_o); // R3
  AST_ERASE_THEN_PROG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_erase_o |=> !fl_prog_o && !fl_lock_o); // R7
endmodule

// File: tb/flash_cmd_seq_test.sv
`timescale 1ns/1ps
module flash_cmd_seq_test;
  localparam int PW = 128;
  localparam int NV = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0, err;
  logic [31:0] in_data = '0, out_data, fl_addr, fl_rdata = '0, buf_data;
  logic        fl_rd, fl_erase, fl_prog, fl_lock, fl_busy = 1'b0;
  logic [6:0]  pidx = '0;

  flash_cmd_seq uut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .err_o(err), .fl_addr_o(fl_addr), .fl_rd_o(fl_rd), .fl_rdata_i(fl_rdata),
    .fl_erase_o(fl_erase), .fl_prog_o(fl_prog), .fl_lock_o(fl_lock),
    .fl_busy_i(fl_busy), .fl_buf_idx_i(pidx), .fl_buf_data_o(buf_data)
  );

  // array model: 4 pages, programming ANDs bits in
  logic [31:0] fmem [0:511];
  logic [31:0] refm [0:511];
  int n_erase = 0, n_prog = 0, n_lock = 0, n_ep = 0, n_err = 0, busy_viol = 0;
  logic [31:0] last_prog = '0, last_lock = '0, last_erase = '1;
  int  bcnt = 0;
  bit  prog_mode = 0, prev_erase = 0;
  logic [8:0] pbase = '0;

  always @(posedge clk) begin
    if (fl_rd) fl_rdata <= fmem[fl_addr[10:2]];
    if (fl_erase) begin
      for (int j = 0; j < PW; j++) fmem[{fl_addr[10:9], 7'(j)}] = '1;
      n_erase++; last_erase = fl_addr; prev_erase = 1;
      fl_busy <= 1'b1; bcnt = 3; prog_mode = 0;
    end else if (fl_prog) begin
      n_prog++; last_prog = fl_addr;
      if (prev_erase && last_erase == fl_addr) n_ep++;
      prev_erase = 0;
      fl_busy <= 1'b1; prog_mode = 1; pidx <= '0; pbase = {fl_addr[10:9], 7'd0};
    end else if (fl_lock) begin
      n_lock++; last_lock = fl_addr; prev_erase = 0;
      fl_busy <= 1'b1; bcnt = 2; prog_mode = 0;
    end else if (fl_busy) begin
      if (prog_mode) begin
        fmem[pbase + 9'(pidx)] = fmem[pbase + 9'(pidx)] & buf_data;
        if (pidx == 7'(PW - 1)) fl_busy <= 1'b0;
        else pidx <= pidx + 7'd1;
      end else begin
        bcnt--;
        if (bcnt == 0) fl_busy <= 1'b0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && fl_busy && in_ready) busy_viol++;
    if (rst_n && err) n_err++;
  end

  int checks = 0, bad = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w);
    @(negedge clk); in_valid = 1'b1; in_data = w;
    while (!in_ready) @(negedge clk);
    @(posedge clk); #0.5; in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (!(in_ready && !fl_busy)) @(negedge clk);
  endtask

  task automatic read_chk(input logic [31:0] a, input int n, input string tag);
    send({16'(n), 8'h00, 8'h1E});
    send(a);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); out_ready = 1'b1;
      while (!out_valid) @(negedge clk);
      chk(tag, out_data, refm[9'(a[10:2] + 9'(k))]);
      @(posedge clk); #0.5; out_ready = 1'b0;
    end
    wait_idle();
  endtask

  function automatic logic [31:0] wdat(input int i, input int k);
    return {8'(i), 8'h5A, 16'(k)} ^ 32'h0F00_0000;
  endfunction

  // {opcode, count, byte address}
  localparam logic [55:0] VECS [0:NV-1] = '{
    {8'h03, 16'd4,   32'h000},  // erase+write inside page 0
    {8'h1E, 16'd5,   32'h000},  // read back incl. erased neighbour
    {8'h01, 16'd3,   32'h1F8},  // write across page 0/1 boundary
    {8'h04, 16'd130, 32'h200},  // erase+write+lock, pages 1 and 2
    {8'h1E, 16'd3,   32'h3FC},  // read across page 1/2
    {8'h02, 16'd2,   32'h600},  // write+lock, page 3
    {8'h07, 16'd2,   32'h100},  // unknown code
    {8'h03, 16'd2,   32'h102},  // misaligned
    {8'h01, 16'd0,   32'h300},  // zero count
    {8'h03, 16'd1,   32'h5FC},  // single word at last index
    {8'h1E, 16'd1,   32'h7FC}   // last word of memory
  };

  initial begin
    for (int j = 0; j < 512; j++) begin
      fmem[j] = 32'hF0F0_0000 | 32'(j);
      refm[j] = 32'hF0F0_0000 | 32'(j);
    end
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 in_ready", {31'd0, in_ready}, 32'd1);
    chk("R10 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R10 err", {31'd0, err}, 32'd0);
    chk("R10 strobes", {28'd0, fl_rd, fl_erase, fl_prog, fl_lock}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 in_ready after release", {31'd0, in_ready}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      logic [7:0]  op;
      logic [15:0] cnt;
      logic [31:0] a;
      bit isbad, er, lk;
      int e0, p0, l0, ep0, r0, npg, nrb;
      op = VECS[i][55:48]; cnt = VECS[i][47:32]; a = VECS[i][31:0];
      isbad = !(op == 8'h1E || (op >= 8'h01 && op <= 8'h04)) || a[1:0] != 2'b00;
      er = (op == 8'h03 || op == 8'h04);
      lk = (op == 8'h02 || op == 8'h04);
      e0 = n_erase; p0 = n_prog; l0 = n_lock; ep0 = n_ep; r0 = n_err;
      if (op == 8'h1E && !isbad) begin
        read_chk(a, int'(cnt), $sformatf("R2 vec%0d read", i));
        chk("R1 read err", 32'(n_err - r0), 32'd0);
      end else begin
        send({cnt, 8'hA7, op});  // bits [15:8] noise, must be ignored
        send(a);
        if (!isbad)
          for (int k = 0; k < int'(cnt); k++) send(wdat(i, k));
        wait_idle();
        if (isbad) begin
          chk($sformatf("R3 vec%0d err pulse", i), 32'(n_err - r0), 32'd1);
          chk($sformatf("R3 vec%0d no access", i),
              32'(n_erase - e0 + n_prog - p0 + n_lock - l0), 32'd0);
        end else if (cnt == 0) begin
          chk("R4 zero count err", 32'(n_err - r0), 32'd0);
          chk("R4 zero count access", 32'(n_erase - e0 + n_prog - p0 + n_lock - l0), 32'd0);
        end else begin
          npg = int'((a + 32'(cnt) * 4 - 4) >> 9) - int'(a >> 9) + 1;
          if (er)
            for (int pg = int'(a >> 9); pg < int'(a >> 9) + npg; pg++)
              for (int j = 0; j < PW; j++) refm[pg * PW + j] = '1;
          for (int k = 0; k < int'(cnt); k++)
            refm[9'(a[10:2] + 9'(k))] = refm[9'(a[10:2] + 9'(k))] & wdat(i, k);
          chk($sformatf("R1 vec%0d err", i), 32'(n_err - r0), 32'd0);
          chk($sformatf("R6 vec%0d programs", i), 32'(n_prog - p0), 32'(npg));
          chk($sformatf("R6 vec%0d last prog addr", i), last_prog,
              (a + 32'(cnt) * 4 - 4) & 32'hFFFF_FE00);
          chk($sformatf("R7 vec%0d erases", i), 32'(n_erase - e0), er ? 32'(npg) : 32'd0);
          chk($sformatf("R7 vec%0d erase before prog", i), 32'(n_ep - ep0), er ? 32'(npg) : 32'd0);
          chk($sformatf("R8 vec%0d locks", i), 32'(n_lock - l0), lk ? 32'd1 : 32'd0);
          if (lk) chk($sformatf("R8 vec%0d lock addr", i), last_lock,
                      (a + 32'(cnt) * 4 - 4) & 32'hFFFF_FE00);
          nrb = (a + 32'(cnt) * 4 < 32'h800) ? int'(cnt) + 1 : int'(cnt);
          read_chk(a, nrb, $sformatf("R5 vec%0d readback", i));
        end
      end
    end

    // R2 backpressure: word held while consumer stalls
    begin
      logic [31:0] held;
      send({16'd2, 8'h00, 8'h1E});
      send(32'h000);
      @(negedge clk);
      while (!out_valid) @(negedge clk);
      held = out_data;
      repeat (3) @(negedge clk);
      chk("R2 stall valid", {31'd0, out_valid}, 32'd1);
      chk("R2 stall data", out_data, held);
      chk("R2 stall first word", held, refm[0]);
      out_ready = 1'b1;
      @(posedge clk); #0.5; out_ready = 1'b0;
      @(negedge clk);
      while (!out_valid) @(negedge clk);
      chk("R2 second word", out_data, refm[1]);
      out_ready = 1'b1;
      @(posedge clk); #0.5; out_ready = 1'b0;
      wait_idle();
    end

    chk("R9 ready while busy", 32'(busy_viol), 32'd0);
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule